// File: doc/BRIEF.md
# Token Bus Transmit Sequencer

This block decides, frame by frame, what a node puts on a token-passing bus while it holds the token. It takes decoded receive events and a microsecond tick. The events are an invitation-to-transmit with its destination ID, an acknowledge, a negative acknowledge, and a line-activity flag. It issues one-cycle commands to a separate frame transmitter: send a free-buffer enquiry, send the pending packet, or send an invitation to a chosen next node. Physical encoding, CRC and packet storage sit elsewhere.

A host asks for a transmission by pulsing a request together with a broadcast flag. The block then clears its transmitter-available flag (TA) and its message-acknowledged flag (TMA). When an invitation names the node's own ID, the sequencer runs one of three paths and always finishes by passing the token. If TA is already set, it passes the token at once. For a directed packet, it sends an enquiry first and sends the packet only after an acknowledge. For a broadcast, it sends the packet straight away. Every wait for a reply is a silence window measured in ticks. The successor node is found by stepping the next-ID register after each invitation that goes unanswered.

States: IDLE, ENQ (enquiry command), ENQ_WAIT, PKT (packet command), PKT_WAIT, PASS (invitation command), PASS_WAIT.

Transitions:
- IDLE→PASS: invited while TA=1.
- IDLE→PKT: invited with a broadcast pending.
- IDLE→ENQ: invited with a directed packet pending.
- ENQ→ENQ_WAIT.
- ENQ_WAIT→PKT: on acknowledge.
- ENQ_WAIT→PASS: on negative acknowledge, other activity, or window expiry.
- PKT→PASS: broadcast.
- PKT→PKT_WAIT: directed packet.
- PKT_WAIT→PASS: on any outcome.
- PASS→PASS_WAIT.
- PASS_WAIT→IDLE: on activity, or when the next step would reach the node's own ID.
- PASS_WAIT→PASS: on expiry, with the next ID stepped.

Top module: `token_tx_seq`

## Requirements
- R1: After reset TA=1 and TMA=0, and no command output is asserted.
- R2: A host request pulse is accepted only while TA=1. It clears TA and TMA and latches the broadcast flag. A request made while TA=0 is ignored and leaves the latched broadcast flag unchanged.
- R3: An invitation whose destination ID differs from the node's own ID is ignored. So is any invitation that arrives while the sequencer is not in IDLE.
- R4: When an invitation for this node arrives while TA=1, the next cycle carries an invitation command and no enquiry or packet command.
- R5: With a directed packet pending, an invitation for this node produces an enquiry command. An acknowledge received in ENQ_WAIT then produces a packet command.
- R6: In ENQ_WAIT, a negative acknowledge, other line activity, or window expiry produces an invitation command and no packet. TA stays 0, so the packet is tried again at the next token.
- R7: With a broadcast pending, the packet command is issued without an enquiry. TA reads 1 in the cycle after the packet command, and an invitation command follows.
- R8: After a directed packet, an acknowledge sets both TMA and TA. Window expiry sets TA only. Either outcome is followed by an invitation command.
- R9: After an invitation command, line activity in PASS_WAIT returns the sequencer to IDLE with no further command.
- R10: The first invitation after reset targets own ID + 1. Each expired invitation window steps the next ID by one and reissues the invitation. The step from 255 goes to 1, and ID 0 is never targeted.
- R11: When the stepped ID would equal the node's own ID, no further invitation is sent. The next ID keeps its last value for the next token.
- R12: A silence window expires on the SIL_TICKS-th tick counted from the start of the wait, and not earlier.
- R13: Each command is a single-cycle pulse, and at most one command is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_id | input | ID_W | This node's own ID (nonzero) |
| host_req | input | 1 | Host pulse: a packet is ready |
| host_bcast | input | 1 | Qualifies host_req: the packet is a broadcast |
| rx_itt | input | 1 | Invitation-to-transmit decoded (pulse) |
| rx_itt_did | input | ID_W | Destination ID of that invitation |
| rx_ack | input | 1 | Acknowledge decoded (pulse) |
| rx_nak | input | 1 | Negative acknowledge decoded (pulse) |
| line_active | input | 1 | Activity seen on the line |
| us_tick | input | 1 | Microsecond time base pulse |
| cmd_fbe | output | 1 | Command: send free-buffer enquiry |
| cmd_pkt | output | 1 | Command: send pending packet |
| cmd_itt | output | 1 | Command: send invitation to cmd_itt_nid |
| cmd_itt_nid | output | ID_W | Target ID for the invitation command |
| ta | output | 1 | Transmitter available (nothing pending) |
| tma | output | 1 | Last directed packet was acknowledged |

## Verification
The bench drives ticks one at a time, so the expiry of the silence window can be pinned to its exact tick. A timer that ended one tick early or late would show an invitation too soon or a missing one. It runs an unanswered successor search from own ID 2 all the way around the ID space. A wrong wrap would target ID 0, or keep searching past the node's own ID and send more invitations than expected. It also sends repeat invitations and host requests while the block is busy. A design that failed to ignore them would emit a second enquiry, or send a broadcast where the pending packet was directed. After each packet outcome, the bench compares TA and TMA separately, which exposes a design that sets TMA on silence or leaves TA clear after an acknowledge.

// File: rtl/tbx_pkg.sv
package tbx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENQ,
        ST_ENQ_WAIT,
        ST_PKT,
        ST_PKT_WAIT,
        ST_PASS,
        ST_PASS_WAIT
    } seq_state_t;

endpackage

// File: rtl/tbx_silence_timer.sv
module tbx_silence_timer #(
    parameter int TICKS = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic line_active,
    input  logic us_tick,
    output logic expire
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign expire = arm && !line_active && us_tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || line_active || expire) begin
            cnt <= '0;
        end else if (us_tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tbx_nid_reg.sv
module tbx_nid_reg #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] my_id,
    input  logic            adv,
    output logic [ID_W-1:0] nid,
    output logic            at_self
);
    localparam logic [ID_W-1:0] ID_MAX = '1;
    localparam logic [ID_W-1:0] ID_ONE = ID_W'(1);

    function automatic logic [ID_W-1:0] step_id(input logic [ID_W-1:0] x);
        return (x == ID_MAX || x == '0) ? ID_ONE : x + ID_ONE;
    endfunction

    logic [ID_W-1:0] nid_q;

    assign nid     = (nid_q == '0) ? step_id(my_id) : nid_q;
    assign at_self = (step_id(nid) == my_id);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nid_q <= '0;
        end else if (adv) begin
            nid_q <= step_id(nid);
        end
    end
endmodule

// File: rtl/tbx_status.sv
module tbx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic host_bcast,
    input  logic set_ta,
    input  logic set_tma,
    output logic ta,
    output logic tma,
    output logic bcast
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ta    <= 1'b1;
            tma   <= 1'b0;
            bcast <= 1'b0;
        end else if (host_req && ta) begin
            ta    <= 1'b0;
            tma   <= 1'b0;
            bcast <= host_bcast;
        end else begin
            if (set_ta)  ta  <= 1'b1;
            if (set_tma) tma <= 1'b1;
        end
    end
endmodule

// File: rtl/tbx_tx_fsm.sv
module tbx_tx_fsm
    import tbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic invited,
    input  logic ta,
    input  logic bcast,
    input  logic rx_ack,
    input  logic rx_nak,
    input  logic line_active,
    input  logic expire,
    input  logic at_self,
    output logic cmd_fbe,
    output logic cmd_pkt,
    output logic cmd_itt,
    output logic arm,
    output logic adv,
    output logic set_ta,
    output logic set_tma
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (invited) begin
                    if (ta)         state_nx = ST_PASS;
                    else if (bcast) state_nx = ST_PKT;
                    else            state_nx = ST_ENQ;
                end
            end
            ST_ENQ:      state_nx = ST_ENQ_WAIT;
            ST_ENQ_WAIT: begin
                if (rx_ack)                               state_nx = ST_PKT;
                else if (rx_nak || line_active || expire) state_nx = ST_PASS;
            end
            ST_PKT:      state_nx = bcast ? ST_PASS : ST_PKT_WAIT;
            ST_PKT_WAIT: begin
                if (rx_ack || rx_nak || line_active || expire) state_nx = ST_PASS;
            end
            ST_PASS:     state_nx = ST_PASS_WAIT;
            ST_PASS_WAIT: begin
                if (rx_ack || rx_nak || line_active) state_nx = ST_IDLE;
                else if (expire)                     state_nx = at_self ? ST_IDLE : ST_PASS;
            end
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_fbe = (state == ST_ENQ);
        cmd_pkt = (state == ST_PKT);
        cmd_itt = (state == ST_PASS);
        arm     = (state == ST_ENQ_WAIT) || (state == ST_PKT_WAIT) ||
                  (state == ST_PASS_WAIT);
        adv     = (state == ST_PASS_WAIT) && expire && !at_self &&
                  !rx_ack && !rx_nak;
        set_ta  = ((state == ST_PKT) && bcast) ||
                  ((state == ST_PKT_WAIT) && (rx_ack || (expire && !rx_nak)));
        set_tma = (state == ST_PKT_WAIT) && rx_ack;
    end
endmodule

// File: rtl/token_tx_seq.sv
module token_tx_seq #(
    parameter int ID_W      = 8,
    parameter int SIL_TICKS = 75
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] my_id,
    input  logic            host_req,
    input  logic            host_bcast,
    input  logic            rx_itt,
    input  logic [ID_W-1:0] rx_itt_did,
    input  logic            rx_ack,
    input  logic            rx_nak,
    input  logic            line_active,
    input  logic            us_tick,
    output logic            cmd_fbe,
    output logic            cmd_pkt,
    output logic            cmd_itt,
    output logic [ID_W-1:0] cmd_itt_nid,
    output logic            ta,
    output logic            tma
);
    logic invited, bcast, expire, at_self, arm, adv, set_ta, set_tma;

    assign invited = rx_itt && (rx_itt_did == my_id);

    tbx_silence_timer #(.TICKS(SIL_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .line_active(line_active),
        .us_tick(us_tick), .expire(expire)
    );

    tbx_nid_reg #(.ID_W(ID_W)) u_nid (
        .clk(clk), .rst_n(rst_n), .my_id(my_id), .adv(adv),
        .nid(cmd_itt_nid), .at_self(at_self)
    );

    tbx_status u_status (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_bcast(host_bcast),
        .set_ta(set_ta), .set_tma(set_tma), .ta(ta), .tma(tma), .bcast(bcast)
    );

    tbx_tx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .invited(invited), .ta(ta), .bcast(bcast),
        .rx_ack(rx_ack), .rx_nak(rx_nak), .line_active(line_active),
        .expire(expire), .at_self(at_self), .cmd_fbe(cmd_fbe),
        .cmd_pkt(cmd_pkt), .cmd_itt(cmd_itt), .arm(arm), .adv(adv),
        .set_ta(set_ta), .set_tma(set_tma)
    );
endmodule

// File: rtl/tbx_checker.sv
module tbx_checker #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ID_W-1:0] my_id,
    input logic            host_req,
    input logic            cmd_fbe,
    input logic            cmd_pkt,
    input logic            cmd_itt,
    input logic [ID_W-1:0] cmd_itt_nid,
    input logic            ta,
    input logic            tma
);
    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_fbe, cmd_pkt, cmd_itt}));                              // R13
    AST_PKT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pkt |=> !cmd_pkt);                                                // R13
    AST_ITT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_itt |=> !cmd_itt);                                                // R13
    AST_ITT_TARGET_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_itt |-> (cmd_itt_nid != '0) && (cmd_itt_nid != my_id));          // R10
    AST_TMA_NEEDS_TA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tma) |-> ta);                                                   // R8
    AST_REQ_CLEARS_TA: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && ta) |=> (!ta && !tma));                                  // R2
    AST_PKT_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pkt |-> !ta);                                                     // R5
    AST_FBE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fbe |-> !ta);                                                     // R4
endmodule

bind token_tx_seq tbx_checker #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .my_id(my_id), .host_req(host_req),
    .cmd_fbe(cmd_fbe), .cmd_pkt(cmd_pkt), .cmd_itt(cmd_itt),
    .cmd_itt_nid(cmd_itt_nid), .ta(ta), .tma(tma)
);

// File: tb/sim_token_tx_seq.sv
module sim_token_tx_seq;
    localparam int ID_W = 8;
    localparam int SIL  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ID_W-1:0] my_id = 8'd10;
    logic host_req = 1'b0, host_bcast = 1'b0;
    logic rx_itt = 1'b0;
    logic [ID_W-1:0] rx_itt_did = '0;
    logic rx_ack = 1'b0, rx_nak = 1'b0, line_active = 1'b0, us_tick = 1'b0;
    logic cmd_fbe, cmd_pkt, cmd_itt, ta, tma;
    logic [ID_W-1:0] cmd_itt_nid;

    int n_chk = 0, n_fail = 0;
    int n_fbe = 0, n_pkt = 0, n_itt = 0, n_zero = 0, n_multi = 0;
    int last_nid = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    token_tx_seq #(.ID_W(ID_W), .SIL_TICKS(SIL)) u0 (
        .clk(clk), .rst_n(rst_n), .my_id(my_id), .host_req(host_req),
        .host_bcast(host_bcast), .rx_itt(rx_itt), .rx_itt_did(rx_itt_did),
        .rx_ack(rx_ack), .rx_nak(rx_nak), .line_active(line_active),
        .us_tick(us_tick), .cmd_fbe(cmd_fbe), .cmd_pkt(cmd_pkt),
        .cmd_itt(cmd_itt), .cmd_itt_nid(cmd_itt_nid), .ta(ta), .tma(tma)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_fbe) n_fbe++;
            if (cmd_pkt) n_pkt++;
            if (cmd_itt) begin
                n_itt++;
                last_nid = int'(cmd_itt_nid);
                if (cmd_itt_nid == '0) n_zero++;
            end
            if ((int'(cmd_fbe) + int'(cmd_pkt) + int'(cmd_itt)) > 1) n_multi++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        n_fbe = 0; n_pkt = 0; n_itt = 0; n_zero = 0; n_multi = 0; last_nid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
        end
    endtask

    task automatic invite(input logic [ID_W-1:0] did);
        @(negedge clk) begin rx_itt = 1'b1; rx_itt_did = did; end
        @(negedge clk) rx_itt = 1'b0;
        idle(2);
    endtask

    task automatic ack();
        @(negedge clk) rx_ack = 1'b1;
        @(negedge clk) rx_ack = 1'b0;
        idle(3);
    endtask

    task automatic nak();
        @(negedge clk) rx_nak = 1'b1;
        @(negedge clk) rx_nak = 1'b0;
        idle(3);
    endtask

    task automatic activity();
        @(negedge clk) line_active = 1'b1;
        @(negedge clk) line_active = 1'b0;
        idle(2);
    endtask

    task automatic request(input logic b);
        @(negedge clk) begin host_req = 1'b1; host_bcast = b; end
        @(negedge clk) begin host_req = 1'b0; host_bcast = 1'b0; end
        idle(1);
    endtask

    task automatic do_reset(input logic [ID_W-1:0] id);
        @(negedge clk) rst_n = 1'b0;
        my_id = id;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        clr();
    endtask

    task automatic t_reset();
        check("R1 ta", int'(ta), 1);
        check("R1 tma", int'(tma), 0);
        idle(4);
        check("R1 no commands", n_fbe + n_pkt + n_itt, 0);
    endtask

    task automatic t_foreign_invite();
        clr();
        invite(8'd11);
        invite(8'd9);
        idle(4);
        check("R3 foreign invitation ignored", n_fbe + n_pkt + n_itt, 0);
    endtask

    task automatic t_free_pass();
        clr();
        invite(my_id);
        check("R4 invitation sent", n_itt, 1);
        check("R4 no enquiry or packet", n_fbe + n_pkt, 0);
        check("R10 first target own+1", last_nid, 11);
        activity();
        ticks(SIL + 2);
        check("R9 activity ends pass", n_itt, 1);
    endtask

    task automatic t_directed_ack();
        clr();
        request(1'b0);
        check("R2 request clears ta", int'(ta), 0);
        invite(my_id);
        check("R5 enquiry sent", n_fbe, 1);
        check("R5 no packet before ack", n_pkt, 0);
        ticks(SIL - 2);
        check("R12 no expiry before window", n_itt, 0);
        ack();
        check("R5 packet after ack", n_pkt, 1);
        ack();
        check("R8 ack sets ta", int'(ta), 1);
        check("R8 ack sets tma", int'(tma), 1);
        check("R8 pass after ack", n_itt, 1);
        ticks(SIL - 1);
        check("R12 window not yet expired", n_itt, 1);
        ticks(1);
        idle(2);
        check("R12 expiry on last tick", n_itt, 2);
        check("R10 stepped target", last_nid, 12);
        activity();
    endtask

    task automatic t_enquiry_refused();
        clr();
        request(1'b0);
        invite(my_id);
        nak();
        check("R6 nak no packet", n_pkt, 0);
        check("R6 nak passes token", n_itt, 1);
        check("R6 ta stays 0", int'(ta), 0);
        activity();
        clr();
        invite(my_id);
        check("R6 retry enquiry", n_fbe, 1);
        ticks(SIL);
        idle(2);
        check("R6 silence no packet", n_pkt, 0);
        check("R6 silence passes token", n_itt, 1);
        activity();
        clr();
        invite(my_id);
        activity();
        check("R6 activity no packet", n_pkt, 0);
        check("R6 activity passes token", n_itt, 1);
        activity();
    endtask

    task automatic t_directed_silence();
        clr();
        invite(my_id);
        ack();
        check("R5 packet", n_pkt, 1);
        ticks(SIL);
        idle(2);
        check("R8 silence sets ta", int'(ta), 1);
        check("R8 silence leaves tma", int'(tma), 0);
        check("R8 pass after silence", n_itt, 1);
        activity();
    endtask

    task automatic t_broadcast();
        clr();
        request(1'b1);
        check("R2 bcast request clears ta", int'(ta), 0);
        @(negedge clk) begin rx_itt = 1'b1; rx_itt_did = my_id; end
        @(negedge clk) rx_itt = 1'b0;
        check("R7 packet command now", int'(cmd_pkt), 1);
        @(negedge clk);
        check("R7 ta set after packet", int'(ta), 1);
        idle(2);
        check("R7 no enquiry", n_fbe, 0);
        check("R7 one packet", n_pkt, 1);
        check("R7 token passed", n_itt, 1);
        activity();
    endtask

    task automatic t_busy_ignore();
        clr();
        request(1'b0);
        request(1'b1);
        invite(my_id);
        check("R2 second request ignored", n_fbe, 1);
        check("R2 no broadcast packet", n_pkt, 0);
        invite(my_id);
        check("R3 busy invitation ignored", n_fbe, 1);
        ack();
        ack();
        check("R8 final ta", int'(ta), 1);
        activity();
        check("R13 one command per cycle", n_multi, 0);
    endtask

    task automatic t_ring_search();
        do_reset(8'd2);
        invite(8'd2);
        check("R10 first target own+1", last_nid, 3);
        for (int i = 0; i < 260; i++) ticks(SIL);
        idle(4);
        check("R11 invitations until own id", n_itt, 254);
        check("R10 wrap reaches 1", last_nid, 1);
        check("R10 zero never targeted", n_zero, 0);
        clr();
        invite(8'd2);
        check("R11 next id kept", last_nid, 1);
        activity();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_foreign_invite();
        t_free_pass();
        t_directed_ack();
        t_enquiry_refused();
        t_directed_silence();
        t_broadcast();
        t_busy_ignore();
        t_ring_search();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule